// File: doc/BRIEF.md
# Video Memory Fill Engine

This block performs the fill transfer of a video processor's DMA unit. The control path arms it with a strobe. The engine then reports busy and waits, with no memory traffic. The next data-port write starts the transfer. On that cycle the engine captures the following inputs:

- the transfer length, built from two 8-bit fields;
- the destination code;
- the start address;
- the source-address register pair;
- the data-port write FIFO view and its write index.

It then repeats one value into one of three video memories. These are the byte-wide pattern memory, the 9-bit colour memory or the 16-bit scroll memory. The destination address steps by the auto-increment value after every accepted write.

Each memory has its own write port with valid/ready flow control. The engine holds valid, address and data stable until ready is seen high, and it completes at most one write per clock. An unrecognised destination code writes nothing, but the address is still advanced. When the transfer ends, the engine raises a one-cycle done pulse, drops busy, and presents two results: the final destination address and the source pair advanced by the length. A fill never reads from the source.

Top module: `vmem_fill_engine`

## Requirements
- R1: A high `arm_i` while idle sets `busy_o` on the next clock. No write port asserts valid until a data write arrives. An `arm_i` while busy is ignored, so busy falls at the end of the current fill and stays low.
- R2: A data write (`dwr_i`) while armed starts the fill with length `{len_hi_i,len_lo_i}`. A length of 0 means 65536 writes.
- R3: Code 4'h1 targets the pattern memory. Each write carries the byte address `addr ^ 1` and the data `fifo[(widx-1) mod 4][15:8]`, where entry k occupies bits `[16k+15:16k]` of `fifo_flat_i`.
- R4: Code 4'h3 targets the colour memory. Each write carries the index `addr[6:1]` and 9 bits `{e[11:9],e[7:5],e[3:1]}`, where e is `fifo[widx]`.
- R5: Code 4'h5 targets the scroll memory. Each write carries the index `addr[6:1]` and the 16-bit `fifo[widx]`.
- R6: The first write uses `addr_i`. Each accepted write advances the address by `incr_i` modulo 2^16. After the fill, `addr_o` equals `addr_i + n*incr_i` modulo 2^16, where n is the write count.
- R7: Any other code writes nothing. The fill finishes on the clock that starts it, and `addr_o` becomes `addr_i + n*incr_i` modulo 2^16.
- R8: At the end of the fill, `src_end_o` equals `src_i + length` modulo 2^16.
- R9: While a port's valid is high and its ready is low, the valid, address and data of that port hold. At most one port is valid at a time.
- R10: `done_o` is high for exactly one cycle, beginning on the clock that accepts the last write. `busy_o` is low from that same clock.
- R11: A data write while idle has no effect: busy, done and every valid stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Fill arm command strobe |
| dwr_i | input | 1 | Data-port write strobe |
| fifo_flat_i | input | 64 | Four 16-bit write FIFO entries, entry 0 in the low bits |
| fifo_widx_i | input | 2 | FIFO write index (next free entry) |
| len_lo_i | input | 8 | Length, low byte |
| len_hi_i | input | 8 | Length, high byte |
| src_i | input | 16 | Source-address register pair |
| code_i | input | 4 | Low access-code bits, select destination |
| addr_i | input | 16 | Destination start address |
| incr_i | input | 8 | Auto-increment value |
| vram_wr_valid | output | 1 | Pattern memory write valid |
| vram_wr_ready | input | 1 | Pattern memory ready |
| vram_wr_addr | output | 16 | Pattern memory byte address |
| vram_wr_data | output | 8 | Pattern memory byte |
| cram_wr_valid | output | 1 | Colour memory write valid |
| cram_wr_ready | input | 1 | Colour memory ready |
| cram_wr_idx | output | 6 | Colour memory word index |
| cram_wr_data | output | 9 | Colour memory packed word |
| vsram_wr_valid | output | 1 | Scroll memory write valid |
| vsram_wr_ready | input | 1 | Scroll memory ready |
| vsram_wr_idx | output | 6 | Scroll memory word index |
| vsram_wr_data | output | 16 | Scroll memory word |
| busy_o | output | 1 | Fill armed or in progress |
| done_o | output | 1 | One-cycle end-of-fill pulse |
| addr_o | output | 16 | Current, and at the end final, destination address |
| src_end_o | output | 16 | Source pair advanced by the length |

## Verification
The address-step property compares each new address with the increment seen on the accepting clock. It therefore assumes that `incr_i` stays constant while a fill runs. The bench changes the increment, code, length and FIFO inputs only between fills, so this holds.

The properties also assume that `arm_i` is a single-cycle strobe, which the bench also guarantees. Ready is driven freely from `$urandom` on every port, so back-pressure and hold behaviour are exercised without further restriction.

// File: rtl/vfill_pkg.sv
package vfill_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_VRAM  = 2'd1,
    TGT_CRAM  = 2'd2,
    TGT_VSRAM = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } st_e;

  // Low access-code bits select the destination memory.
  function automatic tgt_e decode_tgt(input logic [3:0] c);
    case (c)
      4'h1:    return TGT_VRAM;
      4'h3:    return TGT_CRAM;
      4'h5:    return TGT_VSRAM;
      default: return TGT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fill_src_pick.sv
module fill_src_pick #(
  parameter int DW     = 16,
  parameter int FDEPTH = 4,
  localparam int FIW   = $clog2(FDEPTH),
  localparam int BW    = DW / 2
) (
  input  logic [FDEPTH*DW-1:0] fifo_flat,
  input  logic [FIW-1:0]       widx,
  output logic [BW-1:0]        newest_hi,
  output logic [DW-1:0]        cur_word,
  output logic [8:0]           cur_packed
);
  logic [DW-1:0] ent [FDEPTH];

  for (genvar g = 0; g < FDEPTH; g++) begin : g_unpack
    assign ent[g] = fifo_flat[g*DW +: DW];
  end

  logic [FIW-1:0] prev_idx;
  assign prev_idx  = widx - FIW'(1);
  assign newest_hi = ent[prev_idx][DW-1:BW];
  assign cur_word  = ent[widx];
  // Three 3-bit colour fields, dropping the pad bit below each.
  assign cur_packed = {cur_word[11:9], cur_word[7:5], cur_word[3:1]};
endmodule

// File: rtl/fill_len_ctr.sv
module fill_len_ctr #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len_in,
  input  logic          dec,
  output logic          last
);
  logic [LW:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (len_in == '0) ? {1'b1, {LW{1'b0}}} : {1'b0, len_in};
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == {{LW{1'b0}}, 1'b1});
endmodule

// File: rtl/vmem_fill_engine.sv
module vmem_fill_engine
  import vfill_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int FDEPTH = 4,
  parameter int IW     = 8,
  parameter int LW     = 16,
  parameter int XW     = 6,
  localparam int FIW   = $clog2(FDEPTH),
  localparam int BW    = DW / 2,
  localparam int HW    = LW / 2,
  localparam int PW    = IW + LW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_i,
  input  logic                 dwr_i,
  input  logic [FDEPTH*DW-1:0] fifo_flat_i,
  input  logic [FIW-1:0]       fifo_widx_i,
  input  logic [HW-1:0]        len_lo_i,
  input  logic [HW-1:0]        len_hi_i,
  input  logic [LW-1:0]        src_i,
  input  logic [3:0]           code_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [IW-1:0]        incr_i,
  output logic                 vram_wr_valid,
  input  logic                 vram_wr_ready,
  output logic [AW-1:0]        vram_wr_addr,
  output logic [BW-1:0]        vram_wr_data,
  output logic                 cram_wr_valid,
  input  logic                 cram_wr_ready,
  output logic [XW-1:0]        cram_wr_idx,
  output logic [8:0]           cram_wr_data,
  output logic                 vsram_wr_valid,
  input  logic                 vsram_wr_ready,
  output logic [XW-1:0]        vsram_wr_idx,
  output logic [DW-1:0]        vsram_wr_data,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [AW-1:0]        addr_o,
  output logic [LW-1:0]        src_end_o
);
  st_e           st_q;
  tgt_e          tgt_q, tgt_new;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] vbyte_q;
  logic [8:0]    cpk_q;
  logic [DW-1:0] cword_q;
  logic [LW-1:0] src_q, len_q, src_end_q;
  logic          done_q;

  logic          launch, fire, last;
  logic [LW-1:0] len_raw;
  logic [LW:0]   len_eff;
  logic [PW-1:0] skip_prod;
  logic [AW-1:0] skip_addr, incr_ext;
  logic [BW-1:0] pick_byte;
  logic [DW-1:0] pick_word;
  logic [8:0]    pick_pk;

  fill_src_pick #(.DW(DW), .FDEPTH(FDEPTH)) u_pick (
    .fifo_flat  (fifo_flat_i),
    .widx       (fifo_widx_i),
    .newest_hi  (pick_byte),
    .cur_word   (pick_word),
    .cur_packed (pick_pk)
  );

  assign launch  = (st_q == ST_PEND) && dwr_i;
  assign tgt_new = decode_tgt(code_i);
  assign len_raw = {len_hi_i, len_lo_i};
  assign len_eff = (len_raw == '0) ? {1'b1, {LW{1'b0}}} : {1'b0, len_raw};
  assign skip_prod = {{(LW+1){1'b0}}, incr_i} * {{IW{1'b0}}, len_eff};
  assign skip_addr = addr_i + skip_prod[AW-1:0];
  assign incr_ext  = {{(AW-IW){1'b0}}, incr_i};

  assign fire = (st_q == ST_RUN) &&
                (((tgt_q == TGT_VRAM)  && vram_wr_ready) ||
                 ((tgt_q == TGT_CRAM)  && cram_wr_ready) ||
                 ((tgt_q == TGT_VSRAM) && vsram_wr_ready));

  fill_len_ctr #(.LW(LW)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (launch),
    .len_in (len_raw),
    .dec    (fire),
    .last   (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tgt_q     <= TGT_NONE;
      addr_q    <= '0;
      vbyte_q   <= '0;
      cpk_q     <= '0;
      cword_q   <= '0;
      src_q     <= '0;
      len_q     <= '0;
      src_end_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (arm_i) st_q <= ST_PEND;
        end
        ST_PEND: begin
          if (dwr_i) begin
            tgt_q   <= tgt_new;
            src_q   <= src_i;
            len_q   <= len_raw;
            vbyte_q <= pick_byte;
            cpk_q   <= pick_pk;
            cword_q <= pick_word;
            if (tgt_new == TGT_NONE) begin
              addr_q    <= skip_addr;
              src_end_q <= src_i + len_raw;
              done_q    <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              addr_q <= addr_i;
              st_q   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (fire) begin
            addr_q <= addr_q + incr_ext;
            if (last) begin
              st_q      <= ST_IDLE;
              done_q    <= 1'b1;
              src_end_q <= src_q + len_q;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign vram_wr_valid  = (st_q == ST_RUN) && (tgt_q == TGT_VRAM);
  assign cram_wr_valid  = (st_q == ST_RUN) && (tgt_q == TGT_CRAM);
  assign vsram_wr_valid = (st_q == ST_RUN) && (tgt_q == TGT_VSRAM);
  assign vram_wr_addr   = {addr_q[AW-1:1], ~addr_q[0]};
  assign vram_wr_data   = vbyte_q;
  assign cram_wr_idx    = addr_q[XW:1];
  assign cram_wr_data   = cpk_q;
  assign vsram_wr_idx   = addr_q[XW:1];
  assign vsram_wr_data  = cword_q;
  assign busy_o         = (st_q != ST_IDLE);
  assign done_o         = done_q;
  assign addr_o         = addr_q;
  assign src_end_o      = src_end_q;
endmodule

// File: rtl/vfill_checker.sv
module vfill_checker #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IW = 8,
  parameter int XW = 6,
  localparam int BW = DW / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm_i,
  input logic [IW-1:0] incr_i,
  input logic          vram_wr_valid,
  input logic          vram_wr_ready,
  input logic [AW-1:0] vram_wr_addr,
  input logic [BW-1:0] vram_wr_data,
  input logic          cram_wr_valid,
  input logic          cram_wr_ready,
  input logic [XW-1:0] cram_wr_idx,
  input logic [8:0]    cram_wr_data,
  input logic          vsram_wr_valid,
  input logic          vsram_wr_ready,
  input logic [XW-1:0] vsram_wr_idx,
  input logic [DW-1:0] vsram_wr_data,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] addr_o
);
  logic any_fire;
  assign any_fire = (vram_wr_valid && vram_wr_ready) ||
                    (cram_wr_valid && cram_wr_ready) ||
                    (vsram_wr_valid && vsram_wr_ready);

  a_r9_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_wr_valid, cram_wr_valid, vsram_wr_valid}));

  a_r9_vram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vram_wr_valid && !vram_wr_ready |=>
      vram_wr_valid && $stable(vram_wr_addr) && $stable(vram_wr_data));

  a_r9_cram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cram_wr_valid && !cram_wr_ready |=>
      cram_wr_valid && $stable(cram_wr_idx) && $stable(cram_wr_data));

  a_r9_vsram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vsram_wr_valid && !vsram_wr_ready |=>
      vsram_wr_valid && $stable(vsram_wr_idx) && $stable(vsram_wr_data));

  a_r1_busy_from_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(arm_i));

  a_r1_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_wr_valid || cram_wr_valid || vsram_wr_valid) |-> busy_o);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    any_fire |=> addr_o == $past(addr_o) + {{(AW-IW){1'b0}}, $past(incr_i)});
endmodule

bind vmem_fill_engine vfill_checker #(.AW(AW), .DW(DW), .IW(IW), .XW(XW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .arm_i          (arm_i),
  .incr_i         (incr_i),
  .vram_wr_valid  (vram_wr_valid),
  .vram_wr_ready  (vram_wr_ready),
  .vram_wr_addr   (vram_wr_addr),
  .vram_wr_data   (vram_wr_data),
  .cram_wr_valid  (cram_wr_valid),
  .cram_wr_ready  (cram_wr_ready),
  .cram_wr_idx    (cram_wr_idx),
  .cram_wr_data   (cram_wr_data),
  .vsram_wr_valid (vsram_wr_valid),
  .vsram_wr_ready (vsram_wr_ready),
  .vsram_wr_idx   (vsram_wr_idx),
  .vsram_wr_data  (vsram_wr_data),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .addr_o         (addr_o)
);

// File: tb/vmem_fill_engine_test.sv
module vmem_fill_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0, dwr_i = 1'b0;
  logic [15:0] fq [4];
  logic [63:0] fifo_flat_i;
  logic [1:0]  fifo_widx_i = '0;
  logic [7:0]  len_lo_i = '0, len_hi_i = '0, incr_i = '0;
  logic [15:0] src_i = '0, addr_i = '0;
  logic [3:0]  code_i = '0;
  logic vram_wr_valid, vram_wr_ready = 1'b0;
  logic [15:0] vram_wr_addr;
  logic [7:0]  vram_wr_data;
  logic cram_wr_valid, cram_wr_ready = 1'b0;
  logic [5:0]  cram_wr_idx;
  logic [8:0]  cram_wr_data;
  logic vsram_wr_valid, vsram_wr_ready = 1'b0;
  logic [5:0]  vsram_wr_idx;
  logic [15:0] vsram_wr_data;
  logic busy_o, done_o;
  logic [15:0] addr_o, src_end_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign fifo_flat_i = {fq[3], fq[2], fq[1], fq[0]};

  vmem_fill_engine uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vbyte(input logic [1:0] w);
    return fq[w - 2'd1][15:8];
  endfunction
  function automatic logic [8:0] exp_pack(input logic [15:0] e);
    return {e[11:9], e[7:5], e[3:1]};
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // One complete fill: arm, wait, launch, drain with random ready, check end.
  task automatic run_fill(input logic [3:0] code, input logic [15:0] start,
                          input logic [7:0] inc, input logic [15:0] len,
                          input logic [15:0] src, input bit rnd_rdy,
                          input bit arm_mid);
    int n, nexp, j, k;
    logic [15:0] ea;
    bit valid_tgt;
    n = (len == 16'd0) ? 65536 : int'(len);
    nexp = (code == 4'h1 || code == 4'h3 || code == 4'h5) ? n : 0;
    @(negedge clk);
    code_i = code; addr_i = start; incr_i = inc; src_i = src;
    len_lo_i = len[7:0]; len_hi_i = len[15:8];
    fifo_widx_i = 2'($urandom);
    for (int i = 0; i < 4; i++) fq[i] = 16'($urandom);
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    chk(busy_o == 1'b1, "R1", "busy after arm", busy_o, 1);
    for (int i = 0; i < 2; i++) begin
      vram_wr_ready = 1'b1; cram_wr_ready = 1'b1; vsram_wr_ready = 1'b1;
      #1;
      chk(!(vram_wr_valid || cram_wr_valid || vsram_wr_valid), "R1",
          "valid while pending", {vram_wr_valid, cram_wr_valid, vsram_wr_valid}, 0);
      @(negedge clk);
    end
    dwr_i = 1'b1;
    @(negedge clk);
    dwr_i = 1'b0;
    j = 0; k = 0;
    while (!done_o) begin
      arm_i = arm_mid && (k == 2);
      vram_wr_ready  = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
      cram_wr_ready  = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
      vsram_wr_ready = rnd_rdy ? ($urandom % 4 != 0) : 1'b1;
      #1;
      ea = start + 16'(j * int'(inc));
      case (code)
        4'h1: begin
          valid_tgt = vram_wr_valid && !cram_wr_valid && !vsram_wr_valid;
          if (vram_wr_valid && vram_wr_ready) begin
            chk(vram_wr_addr == (ea ^ 16'd1), "R3", "vram addr", vram_wr_addr, ea ^ 16'd1);
            chk(vram_wr_data == exp_vbyte(fifo_widx_i), "R3", "vram data",
                vram_wr_data, exp_vbyte(fifo_widx_i));
            j++;
          end
        end
        4'h3: begin
          valid_tgt = cram_wr_valid && !vram_wr_valid && !vsram_wr_valid;
          if (cram_wr_valid && cram_wr_ready) begin
            chk(cram_wr_idx == ea[6:1], "R4", "cram idx", cram_wr_idx, ea[6:1]);
            chk(cram_wr_data == exp_pack(fq[fifo_widx_i]), "R4", "cram data",
                cram_wr_data, exp_pack(fq[fifo_widx_i]));
            j++;
          end
        end
        4'h5: begin
          valid_tgt = vsram_wr_valid && !vram_wr_valid && !cram_wr_valid;
          if (vsram_wr_valid && vsram_wr_ready) begin
            chk(vsram_wr_idx == ea[6:1], "R5", "vsram idx", vsram_wr_idx, ea[6:1]);
            chk(vsram_wr_data == fq[fifo_widx_i], "R5", "vsram data",
                vsram_wr_data, fq[fifo_widx_i]);
            j++;
          end
        end
        default: valid_tgt = 1'b0;
      endcase
      if (!valid_tgt) begin
        chk(1'b0, "R9", "target port valid", {vram_wr_valid, cram_wr_valid, vsram_wr_valid}, 0);
        break;
      end
      k++;
      if (k > 190000) begin
        chk(1'b0, "R10", "fill never ended", j, nexp);
        finish_run();
      end
      @(negedge clk);
    end
    arm_i = 1'b0;
    if (nexp == 0)
      chk(!(vram_wr_valid || cram_wr_valid || vsram_wr_valid), "R7", "no write on bad code",
          {vram_wr_valid, cram_wr_valid, vsram_wr_valid}, 0);
    chk(j == nexp, "R2", "write count", j, nexp);
    ea = start + 16'(n * int'(inc));
    chk(addr_o == ea, (nexp == 0) ? "R7" : "R6", "final addr", addr_o, ea);
    chk(src_end_o == src + len, "R8", "src end", src_end_o, src + len);
    chk(busy_o == 1'b0, "R10", "busy at done", busy_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R10", "done one cycle", done_o, 0);
    chk(busy_o == 1'b0, "R1", "arm during run ignored", busy_o, 0);
  endtask

  initial begin
    #1_900_000;
    chk(1'b0, "R10", "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) fq[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o, "R10", "reset idle", {busy_o, done_o}, 0);
    chk(addr_o == 16'd0 && src_end_o == 16'd0, "R6", "reset addr", addr_o, 0);
    // R11: data write while idle.
    dwr_i = 1'b1;
    @(negedge clk);
    dwr_i = 1'b0;
    chk(!busy_o && !done_o && !(vram_wr_valid || cram_wr_valid || vsram_wr_valid),
        "R11", "idle data write", {busy_o, done_o, vram_wr_valid}, 0);
    @(negedge clk);
    chk(!busy_o, "R11", "still idle", busy_o, 0);
    // Directed corners.
    run_fill(4'h1, 16'h1234, 8'd1, 16'd1, 16'h0100, 1'b0, 1'b0);
    run_fill(4'h3, 16'h007E, 8'd2, 16'd3, 16'hFFFF, 1'b1, 1'b0);
    run_fill(4'h5, 16'hFFF0, 8'd4, 16'd9, 16'hFFFE, 1'b1, 1'b1);
    run_fill(4'h0, 16'h0040, 8'd3, 16'd5, 16'h0010, 1'b0, 1'b0);
    run_fill(4'h7, 16'h0001, 8'd2, 16'd0, 16'h2222, 1'b0, 1'b0);
    run_fill(4'h1, 16'h0100, 8'd0, 16'd4, 16'h0000, 1'b1, 1'b0);
    run_fill(4'h1, 16'h8000, 8'd2, 16'd0, 16'h4000, 1'b0, 1'b0);
    // Random fills.
    for (int t = 0; t < 40; t++) begin
      logic [3:0] c;
      case ($urandom % 8)
        0, 1: c = 4'h1;
        2, 3: c = 4'h3;
        4, 5: c = 4'h5;
        default: c = 4'($urandom);
      endcase
      run_fill(c, 16'($urandom), 8'($urandom), 16'(1 + $urandom % 24),
               16'($urandom), 1'b1, ($urandom % 3) == 0);
    end
    finish_run();
  end
endmodule